// File: doc/BRIEF.md
# Synthesizer Host Register Interface

This block sits between a byte-wide microprocessor bus and the sound-generation logic of a three-voice synthesizer. The processor writes configuration bytes for each voice and for the shared filter and output stage. The block keeps only the bits that carry meaning and presents them as parallel fields to the voice, envelope, filter and volume datapaths. Four status locations can be read back: two potentiometer readings, the upper byte of voice 3's oscillator and voice 3's envelope level. Every register is one-way. A location can be written or read, never both, and the three highest addresses are unused.

A transfer happens only while chip select is low and the transfer-phase input is high. The read/write line picks the direction. Reads are combinational: data and its output-enable appear in the same cycle the read is presented. Reset is qualified: the reset line must be seen low on ten consecutive clock edges before anything is cleared, so a short glitch has no effect. A free-running 512-cycle sampler turns two comparator threshold inputs into 8-bit potentiometer values.

Top module: `synth_host_regs`

## Requirements
- R1: When rst_n is sampled low on 10 consecutive rising edges, every stored field and both pot values become zero at the 10th edge. They stay zero while rst_n remains low.
- R2: A low pulse on rst_n that covers 9 or fewer consecutive rising edges changes no stored field.
- R3: A write stores wdata at the rising edge where cs_n=0, xfer_ph=1 and rw_rd=0. With cs_n=1 or xfer_ph=0, nothing is stored.
- R4: Voice v (0..2) occupies addresses 7v..7v+6:
  - +0: freq[7:0]; +1: freq[15:8].
  - +2: pulse width [7:0]; +3 bits[3:0]: pulse width [11:8].
  - +4: control byte, passed through whole.
  - +5: attack [7:4], decay [3:0].
  - +6: sustain [7:4], release [3:0].
  - Each field appears on its output after the write edge.
- R5: Address 0x15 bits[2:0] set cutoff[2:0], and 0x16 sets cutoff[10:3]. Address 0x17 sets resonance from [7:4] and routing from [3:0]: bit3 external, bit2 voice 3, bit1 voice 2, bit0 voice 1.
- R6: Address 0x18 sets these fields: bit7 voice-3 mute, bit6 high-pass, bit5 band-pass, bit4 low-pass (mode_o = {hp,bp,lp}), and bits[3:0] volume.
- R7: Writes to addresses 0x19 through 0x1F change no stored field.
- R8: rdata_oe is high exactly when cs_n=0, xfer_ph=1 and rw_rd=1, in the same cycle. While rdata_oe is low, rdata is 0x00.
- R9: Reads return these values: 0x19 the X pot value, 0x1A the Y pot value, 0x1B osc3_byte, 0x1C env3_byte.
- R10: Reads of addresses 0x00 through 0x18 and 0x1D through 0x1F return 0x00.
- R11: Each pot period lasts 512 cycles. The first period starts at the edge after a clear. The first 256 edges of a period form the window. The pot value counts the window edges on which the threshold is sampled low before it is first sampled high, saturating at 255. The count is latched on the 512th edge and stays readable unchanged for the next 512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, qualified by a 10-edge low count |
| cs_n | input | 1 | Active-low chip select |
| xfer_ph | input | 1 | Transfer phase; a transfer happens only while this is high |
| rw_rd | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not enabled |
| rdata_oe | output | 1 | High during a valid read |
| pot_x_thr | input | 1 | X pot comparator output, high once the threshold is crossed |
| pot_y_thr | input | 1 | Y pot comparator output |
| osc3_byte | input | 8 | Upper byte of voice 3 oscillator |
| env3_byte | input | 8 | Voice 3 envelope level |
| freq_o | output | 48 | Voice frequencies, voice v at [16v+15:16v] |
| pw_o | output | 36 | Pulse widths, voice v at [12v+11:12v] |
| ctrl_o | output | 24 | Control bytes, voice v at [8v+7:8v] |
| attack_o | output | 12 | Attack codes, 4 bits per voice |
| decay_o | output | 12 | Decay codes, 4 bits per voice |
| sustain_o | output | 12 | Sustain levels, 4 bits per voice |
| release_o | output | 12 | Release codes, 4 bits per voice |
| cutoff_o | output | 11 | Filter cutoff |
| resonance_o | output | 4 | Filter resonance |
| route_o | output | 4 | Filter routing {ext,v3,v2,v1} |
| mode_o | output | 3 | Filter mode {hp,bp,lp} |
| v3_off_o | output | 1 | Voice 3 direct-path mute |
| volume_o | output | 4 | Master volume |

## Verification
Wrong decode state or a corrupted field shows up on the parallel outputs at the sample after the write edge that caused it. A field that lands in the wrong slot therefore appears in the next sweep comparison. A reset qualifier stuck in the wrong state shows up within one pulse: either a 9-edge pulse wipes the fields, or a 10-edge pulse leaves them intact. A sampler whose period counter or window bookkeeping is off returns a wrong pot value at the first latch, 512 cycles after the clear. It can also change the value one period early or late, which the reads on either side of the 1024th edge expose.

// File: rtl/synth_regs_pkg.sv
package synth_regs_pkg;

    localparam int NUM_VOICES     = 3;
    localparam int REGS_PER_VOICE = 7;
    localparam int ADDR_W         = 5;
    localparam int DATA_W         = 8;
    localparam int FREQ_W         = 16;
    localparam int PW_W           = 12;
    localparam int NIB_W          = 4;
    localparam int CUT_W          = 11;

    localparam logic [ADDR_W-1:0] A_CUT_LO    = 5'h15;
    localparam logic [ADDR_W-1:0] A_CUT_HI    = 5'h16;
    localparam logic [ADDR_W-1:0] A_RES_ROUTE = 5'h17;
    localparam logic [ADDR_W-1:0] A_MODE_VOL  = 5'h18;
    localparam logic [ADDR_W-1:0] A_POT_X     = 5'h19;
    localparam logic [ADDR_W-1:0] A_POT_Y     = 5'h1A;
    localparam logic [ADDR_W-1:0] A_OSC3      = 5'h1B;
    localparam logic [ADDR_W-1:0] A_ENV3      = 5'h1C;

    // reset qualifier: running, counting low samples, holding clear
    typedef enum logic [1:0] {
        RQ_RUN   = 2'd0,
        RQ_COUNT = 2'd1,
        RQ_HOLD  = 2'd2
    } rq_state_e;

    // pot sampler: inside the measuring window, or waiting for period end
    typedef enum logic {
        PS_WINDOW = 1'b0,
        PS_IDLE   = 1'b1
    } ps_state_e;

endpackage

// File: rtl/synth_rst_qual.sv
module synth_rst_qual
    import synth_regs_pkg::*;
#(
    parameter int MIN_LOW = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic clear_o
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);

    rq_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RQ_RUN: begin
                if (!rst_n) begin
                    state_d = RQ_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            RQ_COUNT: begin
                if (rst_n) begin
                    state_d = RQ_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(MIN_LOW - 1)) begin
                    state_d = RQ_HOLD;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            RQ_HOLD: begin
                if (rst_n) begin
                    state_d = RQ_RUN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = RQ_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        clear_o = 1'b0;
        unique case (state_q)
            RQ_COUNT: clear_o = !rst_n && (cnt_q == CNT_W'(MIN_LOW - 1));
            RQ_HOLD:  clear_o = !rst_n;
            default:  clear_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/synth_pot_sampler.sv
module synth_pot_sampler
    import synth_regs_pkg::*;
#(
    parameter int PERIOD   = 512,
    parameter int WINDOW   = 256,
    parameter int CHANNELS = 2,
    parameter int VAL_W    = 8
) (
    input  logic                      clk,
    input  logic                      clear_i,
    input  logic [CHANNELS-1:0]       thr_i,
    output logic [CHANNELS*VAL_W-1:0] pot_o
);
    localparam int               PC_W  = $clog2(PERIOD);
    localparam logic [VAL_W-1:0] V_MAX = {VAL_W{1'b1}};

    ps_state_e       state_q, state_d;
    logic [PC_W-1:0] pc_q;
    logic            latch;
    logic            in_window;

    always_ff @(posedge clk) begin
        if (clear_i) begin
            state_q <= PS_WINDOW;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= latch ? '0 : pc_q + PC_W'(1);
        end
    end

    always_comb begin
        state_d   = state_q;
        latch     = 1'b0;
        in_window = 1'b0;
        unique case (state_q)
            PS_WINDOW: begin
                in_window = 1'b1;
                if (pc_q == PC_W'(WINDOW - 1)) state_d = PS_IDLE;
            end
            PS_IDLE: begin
                if (pc_q == PC_W'(PERIOD - 1)) begin
                    latch   = 1'b1;
                    state_d = PS_WINDOW;
                end
            end
            default: state_d = PS_WINDOW;
        endcase
    end

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        logic [VAL_W-1:0] acc_q;
        logic [VAL_W-1:0] val_q;
        logic             hit_q;

        always_ff @(posedge clk) begin
            if (clear_i) begin
                acc_q <= '0;
                val_q <= '0;
                hit_q <= 1'b0;
            end else if (latch) begin
                val_q <= acc_q;
                acc_q <= '0;
                hit_q <= 1'b0;
            end else if (in_window && !hit_q) begin
                if (thr_i[c])           hit_q <= 1'b1;
                else if (acc_q != V_MAX) acc_q <= acc_q + VAL_W'(1);
            end
        end

        assign pot_o[c*VAL_W +: VAL_W] = val_q;
    end

endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_regs_pkg::*;
(
    input  logic                           clk,
    input  logic                           clear_i,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [NUM_VOICES*FREQ_W-1:0]   freq_o,
    output logic [NUM_VOICES*PW_W-1:0]     pw_o,
    output logic [NUM_VOICES*DATA_W-1:0]   ctrl_o,
    output logic [NUM_VOICES*NIB_W-1:0]    attack_o,
    output logic [NUM_VOICES*NIB_W-1:0]    decay_o,
    output logic [NUM_VOICES*NIB_W-1:0]    sustain_o,
    output logic [NUM_VOICES*NIB_W-1:0]    release_o,
    output logic [CUT_W-1:0]               cutoff_o,
    output logic [NIB_W-1:0]               resonance_o,
    output logic [NIB_W-1:0]               route_o,
    output logic [2:0]                     mode_o,
    output logic                           v3_off_o,
    output logic [NIB_W-1:0]               volume_o
);

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        localparam int BASE = v * REGS_PER_VOICE;

        logic [FREQ_W-1:0] freq_q;
        logic [PW_W-1:0]   pw_q;
        logic [DATA_W-1:0] ctrl_q;
        logic [DATA_W-1:0] ad_q;
        logic [DATA_W-1:0] sr_q;
        logic              sel;
        logic [ADDR_W-1:0] ofs;

        assign sel = wr_en_i && (addr_i >= ADDR_W'(BASE))
                             && (addr_i <  ADDR_W'(BASE + REGS_PER_VOICE));
        assign ofs = addr_i - ADDR_W'(BASE);

        always_ff @(posedge clk) begin
            if (clear_i) begin
                freq_q <= '0;
                pw_q   <= '0;
                ctrl_q <= '0;
                ad_q   <= '0;
                sr_q   <= '0;
            end else if (sel) begin
                case (ofs)
                    5'd0:    freq_q[7:0]  <= wdata_i;
                    5'd1:    freq_q[15:8] <= wdata_i;
                    5'd2:    pw_q[7:0]    <= wdata_i;
                    5'd3:    pw_q[11:8]   <= wdata_i[3:0];
                    5'd4:    ctrl_q       <= wdata_i;
                    5'd5:    ad_q         <= wdata_i;
                    5'd6:    sr_q         <= wdata_i;
                    default: ;
                endcase
            end
        end

        assign freq_o   [v*FREQ_W +: FREQ_W] = freq_q;
        assign pw_o     [v*PW_W   +: PW_W]   = pw_q;
        assign ctrl_o   [v*DATA_W +: DATA_W] = ctrl_q;
        assign attack_o [v*NIB_W  +: NIB_W]  = ad_q[7:4];
        assign decay_o  [v*NIB_W  +: NIB_W]  = ad_q[3:0];
        assign sustain_o[v*NIB_W  +: NIB_W]  = sr_q[7:4];
        assign release_o[v*NIB_W  +: NIB_W]  = sr_q[3:0];
    end

    logic [CUT_W-1:0]  cut_q;
    logic [DATA_W-1:0] res_route_q;
    logic [DATA_W-1:0] mode_vol_q;

    always_ff @(posedge clk) begin
        if (clear_i) begin
            cut_q       <= '0;
            res_route_q <= '0;
            mode_vol_q  <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                A_CUT_LO:    cut_q[2:0]  <= wdata_i[2:0];
                A_CUT_HI:    cut_q[10:3] <= wdata_i;
                A_RES_ROUTE: res_route_q <= wdata_i;
                A_MODE_VOL:  mode_vol_q  <= wdata_i;
                default: ;
            endcase
        end
    end

    assign cutoff_o    = cut_q;
    assign resonance_o = res_route_q[7:4];
    assign route_o     = res_route_q[3:0];
    assign v3_off_o    = mode_vol_q[7];
    assign mode_o      = mode_vol_q[6:4];
    assign volume_o    = mode_vol_q[3:0];

endmodule

// File: rtl/synth_host_regs.sv
module synth_host_regs
    import synth_regs_pkg::*;
#(
    parameter int RST_MIN_LOW = 10,
    parameter int POT_PERIOD  = 512,
    parameter int POT_WINDOW  = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        xfer_ph,
    input  logic        rw_rd,
    input  logic [4:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        rdata_oe,
    input  logic        pot_x_thr,
    input  logic        pot_y_thr,
    input  logic [7:0]  osc3_byte,
    input  logic [7:0]  env3_byte,
    output logic [47:0] freq_o,
    output logic [35:0] pw_o,
    output logic [23:0] ctrl_o,
    output logic [11:0] attack_o,
    output logic [11:0] decay_o,
    output logic [11:0] sustain_o,
    output logic [11:0] release_o,
    output logic [10:0] cutoff_o,
    output logic [3:0]  resonance_o,
    output logic [3:0]  route_o,
    output logic [2:0]  mode_o,
    output logic        v3_off_o,
    output logic [3:0]  volume_o
);
    localparam int POT_CH = 2;

    logic                       clear;
    logic                       bus_sel;
    logic                       wr_en;
    logic                       rd_en;
    logic [POT_CH*DATA_W-1:0]   pot_bus;

    assign bus_sel = !cs_n && xfer_ph;
    assign wr_en   = bus_sel && !rw_rd && !clear;
    assign rd_en   = bus_sel && rw_rd;

    synth_rst_qual #(.MIN_LOW(RST_MIN_LOW)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_o (clear)
    );

    synth_pot_sampler #(
        .PERIOD   (POT_PERIOD),
        .WINDOW   (POT_WINDOW),
        .CHANNELS (POT_CH),
        .VAL_W    (DATA_W)
    ) u_pot (
        .clk     (clk),
        .clear_i (clear),
        .thr_i   ({pot_y_thr, pot_x_thr}),
        .pot_o   (pot_bus)
    );

    synth_reg_bank u_bank (
        .clk         (clk),
        .clear_i     (clear),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .freq_o      (freq_o),
        .pw_o        (pw_o),
        .ctrl_o      (ctrl_o),
        .attack_o    (attack_o),
        .decay_o     (decay_o),
        .sustain_o   (sustain_o),
        .release_o   (release_o),
        .cutoff_o    (cutoff_o),
        .resonance_o (resonance_o),
        .route_o     (route_o),
        .mode_o      (mode_o),
        .v3_off_o    (v3_off_o),
        .volume_o    (volume_o)
    );

    assign rdata_oe = rd_en;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_POT_X: rdata = pot_bus[7:0];
                A_POT_Y: rdata = pot_bus[15:8];
                A_OSC3:  rdata = osc3_byte;
                A_ENV3:  rdata = env3_byte;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/synth_host_regs_chk.sv
module synth_host_regs_chk #(
    parameter int MIN_LOW = 10,
    parameter int SNAP_W  = 183
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              xfer_ph,
    input logic              rw_rd,
    input logic [4:0]        addr,
    input logic [3:0]        wdata_lo,
    input logic [7:0]        rdata,
    input logic              rdata_oe,
    input logic [3:0]        vol,
    input logic [SNAP_W-1:0] snap
);
    localparam int LC_W = $clog2(MIN_LOW + 2);

    logic [LC_W-1:0] low_cnt = '0;
    logic            armed   = 1'b0;
    logic            wr_req;

    assign wr_req = !cs_n && xfer_ph && !rw_rd;

    always_ff @(posedge clk) begin
        if (rst_n)                           low_cnt <= '0;
        else if (low_cnt != LC_W'(MIN_LOW))  low_cnt <= low_cnt + LC_W'(1);
        armed <= armed || (!rst_n && low_cnt >= LC_W'(MIN_LOW - 1));
    end

    a_r1_long_low_clears: assert property (@(posedge clk) disable iff (!armed)
        (low_cnt >= LC_W'(MIN_LOW)) |-> (snap == '0));

    a_r2_short_low_keeps: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n && low_cnt < LC_W'(MIN_LOW - 1) && !wr_req) |=> $stable(snap));

    a_r7_upper_write_ignored: assert property (@(posedge clk) disable iff (!armed)
        (rst_n && wr_req && addr >= 5'h19) |=> $stable(snap));

    a_r6_volume_lands: assert property (@(posedge clk) disable iff (!armed)
        (rst_n && wr_req && addr == 5'h18) |=> (vol == $past(wdata_lo)));

    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!armed)
        (cs_n || !xfer_ph) |-> (!rdata_oe && rdata == 8'h00));

    a_r10_write_only_reads_zero: assert property (@(posedge clk) disable iff (!armed)
        (rdata_oe && addr < 5'h19) |-> (rdata == 8'h00));

endmodule

bind synth_host_regs synth_host_regs_chk #(.MIN_LOW(RST_MIN_LOW), .SNAP_W(183)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .xfer_ph  (xfer_ph),
    .rw_rd    (rw_rd),
    .addr     (addr),
    .wdata_lo (wdata[3:0]),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .vol      (volume_o),
    .snap     ({freq_o, pw_o, ctrl_o, attack_o, decay_o, sustain_o, release_o,
                cutoff_o, resonance_o, route_o, mode_o, v3_off_o, volume_o})
);

// File: tb/synth_host_regs_tb_top.sv
module synth_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, xfer_ph, rw_rd;
    logic [4:0]  addr;
    logic [7:0]  wdata, rdata, osc3_byte, env3_byte;
    logic        rdata_oe, pot_x_thr, pot_y_thr;
    logic [47:0] freq_o;
    logic [35:0] pw_o;
    logic [23:0] ctrl_o;
    logic [11:0] attack_o, decay_o, sustain_o, release_o;
    logic [10:0] cutoff_o;
    logic [3:0]  resonance_o, route_o, volume_o;
    logic [2:0]  mode_o;
    logic        v3_off_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    synth_host_regs dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 29 + seed * 53 + 7) & 255);
    endfunction

    task automatic do_reset(input int n);
        @(negedge clk); rst_n = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d,
                          input logic csn, input logic ph);
        @(negedge clk);
        cs_n = csn; xfer_ph = ph; rw_rd = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; xfer_ph = 1'b0; rw_rd = 1'b1;
    endtask

    task automatic bus_rd(input logic [4:0] a, input logic csn, input logic ph,
                          output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = csn; xfer_ph = ph; rw_rd = 1'b1; addr = a;
        #1; d = rdata; oe = rdata_oe;
        #1; cs_n = 1'b1; xfer_ph = 1'b0;
    endtask

    task automatic write_all(input int seed);
        for (int a = 0; a < 25; a++) bus_wr(5'(a), pat(a, seed), 1'b0, 1'b1);
    endtask

    // seed < 0 means every field is expected to be zero
    task automatic check_fields(input int seed, input string tag);
        logic [7:0] p [25];
        for (int a = 0; a < 25; a++) p[a] = (seed < 0) ? 8'h00 : pat(a, seed);
        for (int v = 0; v < 3; v++) begin
            int b = 7 * v;
            chk({tag, " R4 freq"},    64'(freq_o[16*v +: 16]),   64'({p[b+1], p[b]}));
            chk({tag, " R4 pw"},      64'(pw_o[12*v +: 12]),     64'({p[b+3][3:0], p[b+2]}));
            chk({tag, " R4 ctrl"},    64'(ctrl_o[8*v +: 8]),     64'(p[b+4]));
            chk({tag, " R4 attack"},  64'(attack_o[4*v +: 4]),   64'(p[b+5][7:4]));
            chk({tag, " R4 decay"},   64'(decay_o[4*v +: 4]),    64'(p[b+5][3:0]));
            chk({tag, " R4 sustain"}, 64'(sustain_o[4*v +: 4]),  64'(p[b+6][7:4]));
            chk({tag, " R4 release"}, 64'(release_o[4*v +: 4]),  64'(p[b+6][3:0]));
        end
        chk({tag, " R5 cutoff"},    64'(cutoff_o),    64'({p[22], p[21][2:0]}));
        chk({tag, " R5 resonance"}, 64'(resonance_o), 64'(p[23][7:4]));
        chk({tag, " R5 route"},     64'(route_o),     64'(p[23][3:0]));
        chk({tag, " R6 v3off"},     64'(v3_off_o),    64'(p[24][7]));
        chk({tag, " R6 mode"},      64'(mode_o),      64'(p[24][6:4]));
        chk({tag, " R6 volume"},    64'(volume_o),    64'(p[24][3:0]));
    endtask

    task automatic pot_run(input int kx, input int ky);
        logic [7:0] d; logic oe;
        do_reset(10);
        for (int i = 0; i < 512; i++) begin
            pot_x_thr = (i >= kx); pot_y_thr = (i >= ky);
            @(negedge clk);
        end
        bus_rd(5'h19, 1'b0, 1'b1, d, oe);
        chk("R11 pot x", 64'(d), 64'((kx > 255) ? 255 : kx));
        bus_rd(5'h1A, 1'b0, 1'b1, d, oe);
        chk("R11 pot y", 64'(d), 64'((ky > 255) ? 255 : ky));
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d; logic oe;
        rst_n = 1'b0; cs_n = 1'b1; xfer_ph = 1'b0; rw_rd = 1'b1;
        addr = '0; wdata = '0; pot_x_thr = 1'b0; pot_y_thr = 1'b0;
        osc3_byte = 8'hA5; env3_byte = 8'h3C;

        do_reset(12);
        check_fields(-1, "R1 power-up");

        write_all(1); @(negedge clk); check_fields(1, "R3 seed1");
        write_all(2); @(negedge clk); check_fields(2, "R3 seed2");

        // strobes not met: nothing stored
        bus_wr(5'h18, 8'hFF, 1'b1, 1'b1);
        bus_wr(5'h00, 8'hFF, 1'b0, 1'b0);
        @(negedge clk); check_fields(2, "R3 blocked");

        for (int a = 25; a < 32; a++) bus_wr(5'(a), 8'hFF, 1'b0, 1'b1);
        @(negedge clk); check_fields(2, "R7 upper writes");

        for (int a = 0; a < 32; a++) begin
            bus_rd(5'(a), 1'b0, 1'b1, d, oe);
            chk("R8 oe on read", 64'(oe), 64'(1));
            if (a == 27)      chk("R9 osc3", 64'(d), 64'h A5);
            else if (a == 28) chk("R9 env3", 64'(d), 64'h 3C);
            else if (a < 25 || a > 28) chk("R10 zero read", 64'(d), 64'h0);
        end
        osc3_byte = 8'h5E;
        bus_rd(5'h1B, 1'b0, 1'b1, d, oe); chk("R9 osc3 live", 64'(d), 64'h5E);
        bus_rd(5'h1B, 1'b1, 1'b1, d, oe);
        chk("R8 cs high oe", 64'(oe), 64'(0)); chk("R8 cs high data", 64'(d), 64'h0);
        bus_rd(5'h1C, 1'b0, 1'b0, d, oe);
        chk("R8 phase low oe", 64'(oe), 64'(0)); chk("R8 phase low data", 64'(d), 64'h0);

        do_reset(9); @(negedge clk); check_fields(2, "R2 nine-edge pulse");
        do_reset(1); @(negedge clk); check_fields(2, "R2 one-edge pulse");
        do_reset(10); @(negedge clk); check_fields(-1, "R1 ten-edge pulse");

        pot_run(0, 255);
        pot_run(1, 254);
        pot_run(77, 3);
        pot_run(255, 256);
        pot_run(300, 128);

        // refresh period: value holds until the 1024th edge, then updates
        pot_run(40, 90);
        repeat (508) @(negedge clk);
        bus_rd(5'h19, 1'b0, 1'b1, d, oe); chk("R11 held before refresh", 64'(d), 64'd40);
        bus_rd(5'h19, 1'b0, 1'b1, d, oe); chk("R11 refreshed x", 64'(d), 64'd0);
        bus_rd(5'h1A, 1'b0, 1'b1, d, oe); chk("R11 refreshed y", 64'(d), 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule